// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block sits between an external interrupt bus and a group of processors. The bus delivers messages that name a target CPU, a source identifier and two 64-bit data words. The block holds one mailbox per CPU. A mailbox is either idle or busy. A message for an idle mailbox is taken in: the mailbox turns busy, keeps the source and both words, and a single programmable vector is posted to that CPU. A message for a busy mailbox is turned away, and the sender is expected to try again later.

Software reaches the mailboxes through a simple request/response register port. Every mailbox can be addressed directly by index. Three alias addresses always resolve to the mailbox of the CPU that issues the request, so a handler can reach its own entry without knowing its number. Software frees a mailbox by writing its busy bit to zero. The vector that is posted on every accept is held in one shared 6-bit register.

Top module: `cpu_mailbox`

## Requirements
- R1: While reset is applied and after it is released, all busy flags, source fields, data words and the vector are zero. No ack, nack, post or read response is driven, and every output bus reads zero.
- R2: A message whose target mailbox is idle is accepted. `msg_ack` pulses on the cycle after `msg_valid`. The mailbox becomes busy and stores the message's source and both data words.
- R3: A message whose target mailbox is busy is refused. `msg_nack` pulses on the cycle after `msg_valid`, and the mailbox's busy flag, source and data are left unchanged. Ack and nack are never raised together, and neither is raised without a message on the previous cycle.
- R4: On every accept, `post_valid` pulses in the same cycle as `msg_ack`, with `post_cpu` set to the target and `post_vec` set to the vector register value before that edge. When `post_valid` is low, `post_cpu` and `post_vec` are zero.
- R5: A write to address 0x318 loads the vector register from write data bits 5:0. A read of that address returns the vector in bits 5:0 and zero above.
- R6: A read of a busy status word (0x200 + 8*i for CPU i) returns busy in bit 5, the source in bits 4:0, and zero in all other bits.
- R7: A write to a busy status word loads busy from write data bit 5. Write data bits 4:0 do not change the stored source.
- R8: A read of 0x000 + 8*i returns CPU i's data word 0. A read of 0x100 + 8*i returns its data word 1.
- R9: The alias addresses 0x300 (data word 0), 0x308 (data word 1) and 0x310 (busy status, readable and writable) act on the mailbox selected by `reg_cpu`.
- R10: Acceptance uses the busy state registered before the edge. A message that meets a software release in the same cycle is refused. When a message is accepted in the same cycle as a software write to that mailbox's busy bit, the mailbox ends up busy.
- R11: A read request produces `reg_rvalid` and `reg_rdata` on the next cycle, with the data taken from state before that edge. The following read as zero, and writes to them change nothing: addresses with bits 2:0 nonzero, indices at or above the CPU count, and alias slots other than 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_valid | input | 1 | Incoming bus message present this cycle |
| msg_cpu | input | CPU_W | Target CPU of the message |
| msg_src | input | SRC_W | Source identifier of the message |
| msg_data0 | input | DATA_W | First data word |
| msg_data1 | input | DATA_W | Second data word |
| msg_ack | output | 1 | Message accepted (one cycle after msg_valid) |
| msg_nack | output | 1 | Message refused, retry later (one cycle after msg_valid) |
| post_valid | output | 1 | Interrupt vector posted to a CPU |
| post_cpu | output | CPU_W | CPU that receives the posted vector |
| post_vec | output | VEC_W | Posted vector value |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 10 | Byte address of the access |
| reg_cpu | input | CPU_W | CPU issuing the access, used by the alias addresses |
| reg_wdata | input | WR_W | Write data (6 bits: busy at bit 5, vector in 5:0) |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | DATA_W | Read data |

## Verification
Directed sequences first take each mailbox through the accept, refuse and release cycle. Busy status words are read with written source bits, to tell a true source field from one that was overwritten. Messages are then timed to land in the same cycle as a release, or as a set of the busy bit, on the same CPU. This separates acceptance based on registered busy from acceptance that sees the software write first. Alias accesses are issued with different requester IDs, to tell requester-based selection from address-based selection. A long pseudo-random phase mixes messages, reads, writes and unmapped addresses every cycle, to expose wrong priority and cross-talk between mailboxes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W   = 10;
  localparam int BUSY_BIT = 5;

  // address regions, addr[9:8]
  localparam logic [1:0] RG_DATA0 = 2'd0;
  localparam logic [1:0] RG_DATA1 = 2'd1;
  localparam logic [1:0] RG_BUSY  = 2'd2;
  localparam logic [1:0] RG_ALIAS = 2'd3;

  // slots in the alias region, addr[7:3]
  localparam logic [4:0] AL_DATA0 = 5'd0;
  localparam logic [4:0] AL_DATA1 = 5'd1;
  localparam logic [4:0] AL_BUSY  = 5'd2;
  localparam logic [4:0] AL_VEC   = 5'd3;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_DATA0 = 3'd1,
    SEL_DATA1 = 3'd2,
    SEL_BUSY  = 3'd3,
    SEL_VEC   = 3'd4
  } sel_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output sel_e              sel,
  output logic [CPU_W-1:0]  idx
);
  logic [4:0] slot;
  logic       slot_ok;
  logic       req_ok;

  assign slot    = addr[7:3];
  assign slot_ok = int'(slot) < NCPU;
  assign req_ok  = int'(req_cpu) < NCPU;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr[2:0] == 3'd0) begin
      case (addr[9:8])
        RG_DATA0: if (slot_ok) begin sel = SEL_DATA0; idx = slot[CPU_W-1:0]; end
        RG_DATA1: if (slot_ok) begin sel = SEL_DATA1; idx = slot[CPU_W-1:0]; end
        RG_BUSY:  if (slot_ok) begin sel = SEL_BUSY;  idx = slot[CPU_W-1:0]; end
        default: begin
          case (slot)
            AL_DATA0: if (req_ok) begin sel = SEL_DATA0; idx = req_cpu; end
            AL_DATA1: if (req_ok) begin sel = SEL_DATA1; idx = req_cpu; end
            AL_BUSY:  if (req_ok) begin sel = SEL_BUSY;  idx = req_cpu; end
            AL_VEC:   sel = SEL_VEC;
            default:  sel = SEL_NONE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int SRC_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SRC_W-1:0]  src_in,
  input  logic [DATA_W-1:0] d0_in,
  input  logic [DATA_W-1:0] d1_in,
  input  logic              busy_we,
  input  logic              busy_wval,
  output logic              busy_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] d0_q,
  output logic [DATA_W-1:0] d1_q
);
  logic busy_d;
  logic busy_en;

  // an accepted message wins over a software busy write
  always_comb begin
    busy_en = load | busy_we;
    busy_d  = load ? 1'b1 : busy_wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (load) begin
      src_q <= src_in;
      d0_q  <= d0_in;
      d1_q  <= d1_in;
    end
  end
endmodule

// File: rtl/mbx_accept.sv
module mbx_accept #(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3,
  parameter int VEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [CPU_W-1:0] msg_cpu,
  input  logic [NCPU-1:0]  busy_vec,
  input  logic [VEC_W-1:0] vec_q,
  output logic [NCPU-1:0]  load_vec,
  output logic             ack_q,
  output logic             nack_q,
  output logic             post_valid_q,
  output logic [CPU_W-1:0] post_cpu_q,
  output logic [VEC_W-1:0] post_vec_q
);
  logic             cpu_ok;
  logic             tgt_busy;
  logic             accept;
  logic             reject;
  logic             ack_d;
  logic             nack_d;
  logic [CPU_W-1:0] post_cpu_d;
  logic [VEC_W-1:0] post_vec_d;

  always_comb begin
    cpu_ok   = int'(msg_cpu) < NCPU;
    tgt_busy = cpu_ok ? busy_vec[msg_cpu] : 1'b1;
    accept   = msg_valid & ~tgt_busy;
    reject   = msg_valid & tgt_busy;
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_load
    assign load_vec[g] = accept && (msg_cpu == CPU_W'(g));
  end

  always_comb begin
    ack_d      = accept;
    nack_d     = reject;
    post_cpu_d = accept ? msg_cpu : '0;
    post_vec_d = accept ? vec_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q        <= 1'b0;
      nack_q       <= 1'b0;
      post_valid_q <= 1'b0;
      post_cpu_q   <= '0;
      post_vec_q   <= '0;
    end else begin
      ack_q        <= ack_d;
      nack_q       <= nack_d;
      post_valid_q <= ack_d;
      post_cpu_q   <= post_cpu_d;
      post_vec_q   <= post_vec_d;
    end
  end
endmodule

// File: rtl/cpu_mailbox.sv
module cpu_mailbox
  import mbx_pkg::*;
#(
  parameter  int NCPU   = 8,
  parameter  int SRC_W  = 5,
  parameter  int DATA_W = 64,
  parameter  int VEC_W  = 6,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int WR_W   = (VEC_W > BUSY_BIT + 1) ? VEC_W : BUSY_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_data0,
  input  logic [DATA_W-1:0] msg_data1,
  output logic              msg_ack,
  output logic              msg_nack,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [WR_W-1:0]   reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // address decode
  sel_e             sel;
  logic [CPU_W-1:0] idx;
  logic             rd_req;
  logic             wr_req;

  mbx_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dec (
    .addr    (reg_addr),
    .req_cpu (reg_cpu),
    .sel     (sel),
    .idx     (idx)
  );

  assign rd_req = reg_req & ~reg_we;
  assign wr_req = reg_req & reg_we;

  // shared vector register
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_d;
  logic             vec_en;

  always_comb begin
    vec_en = wr_req && (sel == SEL_VEC);
    vec_d  = reg_wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  // accept / refuse and vector posting
  logic [NCPU-1:0] busy_vec;
  logic [NCPU-1:0] load_vec;
  logic [NCPU-1:0] busy_we;

  mbx_accept #(.NCPU(NCPU), .CPU_W(CPU_W), .VEC_W(VEC_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_s),
    .msg_valid    (msg_valid),
    .msg_cpu      (msg_cpu),
    .busy_vec     (busy_vec),
    .vec_q        (vec_q),
    .load_vec     (load_vec),
    .ack_q        (msg_ack),
    .nack_q       (msg_nack),
    .post_valid_q (post_valid),
    .post_cpu_q   (post_cpu),
    .post_vec_q   (post_vec)
  );

  // mailbox storage
  logic [SRC_W-1:0]  src_arr [NCPU];
  logic [DATA_W-1:0] d0_arr  [NCPU];
  logic [DATA_W-1:0] d1_arr  [NCPU];

  for (genvar g = 0; g < NCPU; g++) begin : g_slot
    assign busy_we[g] = wr_req && (sel == SEL_BUSY) && (idx == CPU_W'(g));

    mbx_slot #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_s),
      .load      (load_vec[g]),
      .src_in    (msg_src),
      .d0_in     (msg_data0),
      .d1_in     (msg_data1),
      .busy_we   (busy_we[g]),
      .busy_wval (reg_wdata[BUSY_BIT]),
      .busy_q    (busy_vec[g]),
      .src_q     (src_arr[g]),
      .d0_q      (d0_arr[g]),
      .d1_q      (d1_arr[g])
    );
  end

  // registered read path
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_DATA0: rd_word = d0_arr[idx];
      SEL_DATA1: rd_word = d1_arr[idx];
      SEL_BUSY: begin
        rd_word[BUSY_BIT]    = busy_vec[idx];
        rd_word[SRC_W-1:0]   = src_arr[idx];
      end
      SEL_VEC:   rd_word[VEC_W-1:0] = vec_q;
      default:   rd_word = '0;
    endcase
    rdata_d = rd_req ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_req;
      reg_rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3,
  parameter int VEC_W = 6
) (
  input logic             clk,
  input logic             rst_s,
  input logic             msg_valid,
  input logic [CPU_W-1:0] msg_cpu,
  input logic [NCPU-1:0]  busy_vec,
  input logic             msg_ack,
  input logic             msg_nack,
  input logic             post_valid,
  input logic [VEC_W-1:0] post_vec,
  input logic             reg_req,
  input logic             reg_we,
  input logic             reg_rvalid
);
  a_r2_idle_target_acked: assert property (@(posedge clk) disable iff (!rst_s)
    (msg_valid && !busy_vec[msg_cpu]) |=> msg_ack);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_s)
    msg_ack |-> busy_vec[$past(msg_cpu)]);

  a_r10_busy_target_refused: assert property (@(posedge clk) disable iff (!rst_s)
    (msg_valid && busy_vec[msg_cpu]) |=> msg_nack);

  a_r3_single_response: assert property (@(posedge clk) disable iff (!rst_s)
    !(msg_ack && msg_nack));

  a_r3_response_needs_msg: assert property (@(posedge clk) disable iff (!rst_s)
    (msg_ack || msg_nack) |-> $past(msg_valid));

  a_r4_post_with_ack: assert property (@(posedge clk) disable iff (!rst_s)
    post_valid == msg_ack);

  a_r4_vec_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !post_valid |-> (post_vec == '0));

  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_s)
    reg_rvalid |-> $past(reg_req && !reg_we));
endmodule

bind cpu_mailbox mbx_chk #(.NCPU(NCPU), .CPU_W(CPU_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .msg_valid  (msg_valid),
  .msg_cpu    (msg_cpu),
  .busy_vec   (busy_vec),
  .msg_ack    (msg_ack),
  .msg_nack   (msg_nack),
  .post_valid (post_valid),
  .post_vec   (post_vec),
  .reg_req    (reg_req),
  .reg_we     (reg_we),
  .reg_rvalid (reg_rvalid)
);

// File: tb/cpu_mailbox_test.sv
`timescale 1ns/1ps
module cpu_mailbox_test;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [2:0]  msg_cpu;
  logic [4:0]  msg_src;
  logic [63:0] msg_data0, msg_data1;
  logic        msg_ack, msg_nack, post_valid;
  logic [2:0]  post_cpu;
  logic [5:0]  post_vec;
  logic        reg_req, reg_we;
  logic [9:0]  reg_addr;
  logic [2:0]  reg_cpu;
  logic [5:0]  reg_wdata;
  logic        reg_rvalid;
  logic [63:0] reg_rdata;

  always #2.5 clk = ~clk;

  cpu_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
    .msg_data0(msg_data0), .msg_data1(msg_data1),
    .msg_ack(msg_ack), .msg_nack(msg_nack),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  // behavioural reference state
  bit          m_busy [NC];
  logic [4:0]  m_src  [NC];
  logic [63:0] m_d0   [NC];
  logic [63:0] m_d1   [NC];
  logic [5:0]  m_vec;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";
  int unsigned lcg = 32'h1234_5678;

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  function automatic logic [63:0] busy_word(int i);
    return (m_busy[i] ? 64'h20 : 64'h0) | {59'd0, m_src[i]};
  endfunction

  function automatic logic [63:0] m_read(logic [9:0] a, int c);
    int s;
    s = int'(a[7:3]);
    if (a[2:0] != 3'd0) return 64'd0;
    case (a[9:8])
      2'd0: return (s < NC) ? m_d0[s] : 64'd0;
      2'd1: return (s < NC) ? m_d1[s] : 64'd0;
      2'd2: return (s < NC) ? busy_word(s) : 64'd0;
      default: begin
        if (s == 0) return m_d0[c];
        if (s == 1) return m_d1[c];
        if (s == 2) return busy_word(c);
        if (s == 3) return {58'd0, m_vec};
        return 64'd0;
      end
    endcase
  endfunction

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic idle();
    msg_valid = 0; msg_cpu = 0; msg_src = 0; msg_data0 = 0; msg_data1 = 0;
    reg_req = 0; reg_we = 0; reg_addr = 0; reg_cpu = 0; reg_wdata = 0;
  endtask

  // one clock: predict from current inputs and model, advance, compare
  task automatic step();
    logic        e_ack, e_nack, e_pv, e_rv;
    logic [2:0]  e_pcpu;
    logic [5:0]  e_pvec;
    logic [63:0] e_rd;
    int          s;
    e_ack = 0; e_nack = 0; e_pv = 0; e_pcpu = 0; e_pvec = 0; e_rv = 0; e_rd = 0;
    if (reg_req && !reg_we) begin
      e_rv = 1;
      e_rd = m_read(reg_addr, int'(reg_cpu));
    end
    if (msg_valid) begin
      if (m_busy[msg_cpu]) e_nack = 1;
      else begin
        e_ack = 1; e_pv = 1; e_pcpu = msg_cpu; e_pvec = m_vec;
      end
    end
    if (reg_req && reg_we && reg_addr[2:0] == 3'd0) begin
      s = int'(reg_addr[7:3]);
      if (reg_addr[9:8] == 2'd2 && s < NC) m_busy[s] = reg_wdata[5];
      if (reg_addr[9:8] == 2'd3 && s == 2) m_busy[reg_cpu] = reg_wdata[5];
      if (reg_addr[9:8] == 2'd3 && s == 3) m_vec = reg_wdata;
    end
    if (e_ack) begin
      m_busy[msg_cpu] = 1;
      m_src[msg_cpu]  = msg_src;
      m_d0[msg_cpu]   = msg_data0;
      m_d1[msg_cpu]   = msg_data1;
    end
    @(negedge clk);
    cmp("msg_ack", {63'd0, msg_ack}, {63'd0, e_ack});
    cmp("msg_nack", {63'd0, msg_nack}, {63'd0, e_nack});
    cmp("post_valid", {63'd0, post_valid}, {63'd0, e_pv});
    cmp("post_cpu", {61'd0, post_cpu}, {61'd0, e_pcpu});
    cmp("post_vec", {58'd0, post_vec}, {58'd0, e_pvec});
    cmp("reg_rvalid", {63'd0, reg_rvalid}, {63'd0, e_rv});
    cmp("reg_rdata", reg_rdata, e_rd);
  endtask

  task automatic send(int c, int src, logic [63:0] d0, logic [63:0] d1);
    msg_valid = 1; msg_cpu = 3'(c); msg_src = 5'(src); msg_data0 = d0; msg_data1 = d1;
  endtask

  task automatic rd(logic [9:0] a, int c);
    reg_req = 1; reg_we = 0; reg_addr = a; reg_cpu = 3'(c);
  endtask

  task automatic wr(logic [9:0] a, int c, logic [5:0] d);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_cpu = 3'(c); reg_wdata = d;
  endtask

  task automatic go();
    step();
    idle();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_busy[i] = 0; m_src[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
    end
    m_vec = 0;
    idle();
    rst_n = 0;
    // R1: quiet outputs while reset is held
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("ack in reset", {63'd0, msg_ack}, 64'd0);
      cmp("post in reset", {63'd0, post_valid}, 64'd0);
      cmp("rdata in reset", reg_rdata, 64'd0);
    end
    rst_n = 1;
    for (int i = 0; i < 4; i++) @(negedge clk);

    // R1: state reads zero after reset
    rd(10'h000, 0); go();
    rd(10'h218, 0); go();
    rd(10'h318, 0); go();

    // R2 R8 R6: accept into idle mailbox 2 and read back
    cur_req = "R2";
    send(2, 5'h15, 64'hA5A5_0000_1111_2222, 64'h0123_4567_89AB_CDEF); go();
    cur_req = "R8";
    rd(10'h010, 0); go();
    rd(10'h110, 0); go();
    cur_req = "R6";
    rd(10'h210, 0); go();

    // R3: busy mailbox refuses, contents intact
    cur_req = "R3";
    send(2, 5'h0A, 64'hDEAD, 64'hBEEF); go();
    rd(10'h010, 0); go();
    rd(10'h210, 0); go();

    // R5 R4: program vector, then accept on CPU 5 posts it
    cur_req = "R5";
    wr(10'h318, 0, 6'h2A); go();
    rd(10'h318, 0); go();
    cur_req = "R4";
    send(5, 5'h03, 64'h55, 64'h66); go();
    // R4: vector written with a message in the same cycle posts the old value
    wr(10'h318, 0, 6'h11); send(6, 5'h1E, 64'h77, 64'h88); go();

    // R7: release mailbox 2 with junk source bits
    cur_req = "R7";
    wr(10'h210, 0, 6'h1F); go();
    rd(10'h210, 0); go();

    // R10: release and message in the same cycle are refused
    cur_req = "R10";
    wr(10'h228, 0, 6'h00); send(5, 5'h09, 64'h1, 64'h2); go();
    send(5, 5'h09, 64'h1, 64'h2); go();
    // R10: accept beats a same-cycle busy clear on an idle mailbox
    wr(10'h210, 0, 6'h00); send(2, 5'h04, 64'h3, 64'h4); go();
    rd(10'h210, 0); go();

    // R9: alias addresses follow the requester
    cur_req = "R9";
    rd(10'h300, 5); go();
    rd(10'h308, 6); go();
    rd(10'h310, 2); go();
    wr(10'h310, 2, 6'h00); go();
    rd(10'h210, 0); go();
    wr(10'h310, 0, 6'h20); go();
    rd(10'h200, 0); go();

    // R11: unmapped reads and writes
    cur_req = "R11";
    rd(10'h3F8, 0); go();
    rd(10'h012, 0); go();
    rd(10'h040, 0); go();
    wr(10'h2C0, 0, 6'h20); go();
    wr(10'h320, 0, 6'h3F); go();
    wr(10'h31C, 0, 6'h3F); go();
    for (int i = 0; i < NC; i++) begin
      rd(10'(12'h200 + 8 * i), 0); go();
    end
    rd(10'h318, 0); go();

    // R2 R3 R9 R10 R11: pseudo-random mix
    cur_req = "R2 R3 R9 R10 R11 mix";
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = rnd();
      if (r[0]) send(int'(r[3:1]), int'(r[8:4]),
                     {32'(rnd()), 32'(rnd())}, {32'(rnd()), 32'(rnd())});
      if (r[9]) begin
        logic [1:0] reg_sel;
        logic [4:0] slot;
        reg_sel = r[11:10];
        slot    = (reg_sel == 2'd3) ? 5'(r[14:12] % 5) : 5'(r[15:12] % 10);
        reg_req   = 1;
        reg_we    = r[16];
        reg_addr  = {reg_sel, slot, 3'b000};
        reg_cpu   = r[19:17];
        reg_wdata = r[25:20];
      end
      go();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule